// File: doc/BRIEF.md
# Dual-Link to Single-Link Pixel Interleaver

This block joins two half-rate video links into one full-rate stream. One link carries the odd pixels of a line and the other carries the even pixels. Each pixel is 30 bits of RGB plus data-enable, horizontal sync and vertical sync. The block runs on the output pixel clock `clk`. Each input link presents one pixel per two `clk` cycles, so the input rate is half the output rate. On a capture cycle the block samples both links at once. It emits the link-A pixel on the next cycle and the link-B pixel on the cycle after that. Only one output stream is produced; the second output link stays idle while this merge mode is in use.

A phase flag alternates between the capture cycle and the second-half cycle. A rising edge of the link-A data-enable forces a capture in the cycle where it is seen, so every active region starts with a correctly ordered pair. A checker watches the link-A data-enable. Each high or low run must last an even number of output clocks and at least two. A violation sets a sticky fault flag.

Top module: `dual_link_merge`

## Requirements
- R1: While `rst_n` is low, all pixel outputs and `de_fault` read 0.
- R2: A pixel pair sampled on a capture edge comes out in link-A-then-link-B order. The link-A pixel shows on the outputs after that edge, and the link-B pixel after the following edge. Output pixel bits are {rgb[29:0], de, hs, vs}.
- R3: Inputs are sampled only on capture edges. A change on either link during the second-half cycle does not alter the link-B pixel that follows.
- R4: With no data-enable rising edge, capture edges and second-half edges alternate strictly. The first edge after reset is a capture edge.
- R5: An edge that sees `a_de_i` high after it was low on the previous edge is always a capture edge, whatever the phase was.
- R6: `de_fault` goes to 1 one edge after a data-enable change that ends a run of odd length, counted in output clocks.
- R7: `de_fault` goes to 1 when a data-enable run of a single output clock ends.
- R8: The run in progress at reset, ended by the first data-enable change after reset, is not judged.
- R9: Once set, `de_fault` stays at 1 until reset.
- R10: The sync bits of each output pixel come from the same link as its RGB value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_rgb_i | input | 30 | Link A (odd pixels) colour |
| a_de_i | input | 1 | Link A data enable |
| a_hs_i | input | 1 | Link A horizontal sync |
| a_vs_i | input | 1 | Link A vertical sync |
| b_rgb_i | input | 30 | Link B (even pixels) colour |
| b_de_i | input | 1 | Link B data enable |
| b_hs_i | input | 1 | Link B horizontal sync |
| b_vs_i | input | 1 | Link B vertical sync |
| o_rgb_o | output | 30 | Merged stream colour |
| o_de_o | output | 1 | Merged stream data enable |
| o_hs_o | output | 1 | Merged stream horizontal sync |
| o_vs_o | output | 1 | Merged stream vertical sync |
| de_fault_o | output | 1 | Sticky data-enable timing fault |

## Verification
The assertions check on every cycle the following:
- The output pixel after a capture edge equals the link-A pixel sampled there.
- The pixel after a second-half edge equals the link-B pixel from the preceding capture edge.
- A data-enable rise always yields a link-A pixel next.
- The fault flag never clears.

Only the bench's scenarios can show the following:
- That a misaligned data-enable rise actually realigns the pair order.
- That odd and one-cycle runs raise the fault while even runs do not.
- That the run in progress at reset is exempt from the check.
- That reset clears the fault.

// File: rtl/dlm_pkg.sv
package dlm_pkg;

    // Which link the current edge serves: capture (link A out next) or second half
    typedef enum logic {
        PICK_A = 1'b0,
        PICK_B = 1'b1
    } pick_e;

    // State of the data-enable run checker
    typedef struct packed {
        logic       de_last;
        logic       odd;
        logic [1:0] run;
        logic       armed;
        logic       fault;
    } dechk_t;

endpackage

// File: rtl/dlm_phase.sv
module dlm_phase
    import dlm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  de_i,
    output pick_e pick_o
);

    typedef struct packed {
        pick_e nxt;
        logic  de_last;
    } phase_t;

    phase_t q, d;
    logic   rise;

    always_comb begin
        rise      = de_i & ~q.de_last;
        pick_o    = rise ? PICK_A : q.nxt;
        d.nxt     = (pick_o == PICK_A) ? PICK_B : PICK_A;
        d.de_last = de_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.nxt     <= PICK_A;
            q.de_last <= 1'b0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/dlm_de_check.sv
module dlm_de_check
    import dlm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic de_i,
    output logic fault_o
);

    dechk_t q, d;
    logic   chg;

    always_comb begin
        d         = q;
        chg       = de_i ^ q.de_last;
        d.de_last = de_i;
        if (chg) begin
            d.odd   = 1'b1;
            d.run   = 2'd1;
            d.armed = 1'b1;
            if (q.armed && (q.odd || (q.run < 2'd2))) begin
                d.fault = 1'b1;
            end
        end else begin
            d.odd = ~q.odd;
            d.run = (q.run >= 2'd2) ? 2'd2 : q.run + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign fault_o = q.fault;

    // R9
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> fault_o);

endmodule

// File: rtl/dlm_mux.sv
module dlm_mux
    import dlm_pkg::*;
#(
    parameter int PIX_W = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pick_e            pick_i,
    input  logic [PIX_W-1:0] a_i,
    input  logic [PIX_W-1:0] b_i,
    output logic [PIX_W-1:0] pix_o
);

    typedef struct packed {
        logic [PIX_W-1:0] out;
        logic [PIX_W-1:0] hold;
    } mux_t;

    mux_t q, d;

    always_comb begin
        d = q;
        if (pick_i == PICK_A) begin
            d.out  = a_i;
            d.hold = b_i;
        end else begin
            d.out  = q.hold;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pix_o = q.out;

    // R2
    first_of_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_i == PICK_A) |=> (pix_o == $past(a_i)));

    // R3
    second_of_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pick_i) == PICK_A) && (pick_i == PICK_B)) |=> (pix_o == $past(b_i, 2)));

endmodule

// File: rtl/dual_link_merge.sv
module dual_link_merge
    import dlm_pkg::*;
#(
    parameter int COLOR_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3*COLOR_W-1:0] a_rgb_i,
    input  logic                 a_de_i,
    input  logic                 a_hs_i,
    input  logic                 a_vs_i,
    input  logic [3*COLOR_W-1:0] b_rgb_i,
    input  logic                 b_de_i,
    input  logic                 b_hs_i,
    input  logic                 b_vs_i,
    output logic [3*COLOR_W-1:0] o_rgb_o,
    output logic                 o_de_o,
    output logic                 o_hs_o,
    output logic                 o_vs_o,
    output logic                 de_fault_o
);

    localparam int RGB_W = 3 * COLOR_W;
    localparam int PIX_W = RGB_W + 3;

    logic [PIX_W-1:0] a_pix, b_pix, o_pix;
    pick_e            pick;

    assign a_pix = {a_rgb_i, a_de_i, a_hs_i, a_vs_i};
    assign b_pix = {b_rgb_i, b_de_i, b_hs_i, b_vs_i};

    dlm_phase u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .de_i   (a_de_i),
        .pick_o (pick)
    );

    dlm_mux #(.PIX_W(PIX_W)) u_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .pick_i (pick),
        .a_i    (a_pix),
        .b_i    (b_pix),
        .pix_o  (o_pix)
    );

    dlm_de_check u_chk (
        .clk     (clk),
        .rst_n   (rst_n),
        .de_i    (a_de_i),
        .fault_o (de_fault_o)
    );

    assign o_rgb_o = o_pix[PIX_W-1:3];
    assign o_de_o  = o_pix[2];
    assign o_hs_o  = o_pix[1];
    assign o_vs_o  = o_pix[0];

    // R5
    de_rise_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_de_i && !$past(a_de_i)) |=> (o_pix == $past(a_pix)));

endmodule

// File: tb/dual_link_merge_test.sv
`timescale 1ns/1ps
module dual_link_merge_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] a_rgb, b_rgb, o_rgb;
    logic        a_de, a_hs, a_vs, b_de, b_hs, b_vs;
    logic        o_de, o_hs, o_vs, de_fault;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    dual_link_merge uut (
        .clk(clk), .rst_n(rst_n),
        .a_rgb_i(a_rgb), .a_de_i(a_de), .a_hs_i(a_hs), .a_vs_i(a_vs),
        .b_rgb_i(b_rgb), .b_de_i(b_de), .b_hs_i(b_hs), .b_vs_i(b_vs),
        .o_rgb_o(o_rgb), .o_de_o(o_de), .o_hs_o(o_hs), .o_vs_o(o_vs),
        .de_fault_o(de_fault)
    );

    // entry: {link A rgb, link B rgb, de, hs}; link A vs=0, link B vs=1, link B hs = ~hs
    localparam logic [61:0] VEC [8] = '{
        {30'h0000_0001, 30'h0000_0002, 1'b0, 1'b1},
        {30'h3FFF_FFFF, 30'h0000_0000, 1'b1, 1'b0},
        {30'h1555_5555, 30'h2AAA_AAAA, 1'b1, 1'b0},
        {30'h0123_4567, 30'h089A_BCDE, 1'b0, 1'b1},
        {30'h3F00_00FF, 30'h00FF_FF00, 1'b1, 1'b0},
        {30'h2000_0000, 30'h0000_0001, 1'b0, 1'b0},
        {30'h0F0F_0F0F, 30'h30F0_F0F0, 1'b0, 1'b1},
        {30'h1234_5678, 30'h2468_ACE0, 1'b1, 1'b1}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic drive(input logic [29:0] ar, input logic [29:0] br, input logic de, input logic hs);
        a_rgb = ar; b_rgb = br;
        a_de = de;  b_de = de;
        a_hs = hs;  b_hs = ~hs;
        a_vs = 1'b0; b_vs = 1'b1;
    endtask

    task automatic chk(input string tag, input logic [32:0] got, input logic [32:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [32:0] outp();
        return {o_rgb, o_de, o_hs, o_vs};
    endfunction

    // link A pixel as expected on the output (vs=0), link B pixel (vs=1, hs inverted)
    function automatic logic [32:0] pa(input logic [29:0] r, input logic de, input logic hs);
        return {r, de, hs, 1'b0};
    endfunction
    function automatic logic [32:0] pb(input logic [29:0] r, input logic de, input logic hs);
        return {r, de, ~hs, 1'b1};
    endfunction

    // reset held low for two edges; outputs checked during reset; released at a negedge
    task automatic do_reset();
        rst_n = 1'b0;
        drive(30'h0, 30'h0, 1'b0, 1'b0);
        tick(); tick();
        chk("R1 pixel during reset", outp(), 33'h0);
        chk("R1 fault during reset", {32'h0, de_fault}, 33'h0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        drive(30'h0, 30'h0, 1'b0, 1'b0);
        do_reset();

        // table: each pair held two clocks, aligned to capture edges; all DE runs even
        for (int i = 0; i < 8; i++) begin
            drive(VEC[i][61:32], VEC[i][31:2], VEC[i][1], VEC[i][0]);
            tick();
            chk("R2 R10 link A first", outp(), pa(VEC[i][61:32], VEC[i][1], VEC[i][0]));
            tick();
            chk("R2 R10 link B second", outp(), pb(VEC[i][31:2], VEC[i][1], VEC[i][0]));
        end
        chk("R6 even runs give no fault", {32'h0, de_fault}, 33'h0);

        // R3, R4: inputs changed during the second-half cycle are ignored
        do_reset();
        drive(30'h0AA, 30'h0BB, 1'b0, 1'b0);
        tick();
        chk("R4 first edge after reset captures", outp(), pa(30'h0AA, 1'b0, 1'b0));
        drive(30'h1CC, 30'h1DD, 1'b0, 1'b1);
        tick();
        chk("R3 live link B ignored", outp(), pb(30'h0BB, 1'b0, 1'b0));
        tick();
        chk("R4 next capture", outp(), pa(30'h1CC, 1'b0, 1'b1));
        tick();
        chk("R4 next second half", outp(), pb(30'h1DD, 1'b0, 1'b1));

        // R5: DE rise on a second-half edge forces a capture
        do_reset();
        drive(30'h011, 30'h022, 1'b0, 1'b0);
        tick(); tick(); tick();
        chk("R4 third edge is capture", outp(), pa(30'h011, 1'b0, 1'b0));
        drive(30'h2EE, 30'h3FF, 1'b1, 1'b0);
        tick();
        chk("R5 realigned link A", outp(), pa(30'h2EE, 1'b1, 1'b0));
        tick();
        chk("R5 realigned link B", outp(), pb(30'h3FF, 1'b1, 1'b0));
        chk("R8 first change exempt", {32'h0, de_fault}, 33'h0);

        // R6 and R9: odd low run of three clocks
        do_reset();
        drive(30'h5, 30'h6, 1'b0, 1'b0);
        tick(); tick();
        a_de = 1'b1; b_de = 1'b1;
        tick(); tick();
        a_de = 1'b0; b_de = 1'b0;
        tick(); tick(); tick();
        chk("R6 no fault before odd run ends", {32'h0, de_fault}, 33'h0);
        a_de = 1'b1; b_de = 1'b1;
        tick();
        chk("R6 odd run fault", {32'h0, de_fault}, 33'h1);
        for (int k = 0; k < 10; k++) tick();
        chk("R9 fault sticky", {32'h0, de_fault}, 33'h1);
        do_reset();
        tick();
        chk("R9 reset clears fault", {32'h0, de_fault}, 33'h0);

        // R7: single-clock high run
        do_reset();
        drive(30'h7, 30'h8, 1'b0, 1'b0);
        tick(); tick();
        a_de = 1'b1; b_de = 1'b1;
        tick(); tick();
        a_de = 1'b0; b_de = 1'b0;
        tick(); tick();
        a_de = 1'b1; b_de = 1'b1;
        tick();
        chk("R7 no fault before short run ends", {32'h0, de_fault}, 33'h0);
        a_de = 1'b0; b_de = 1'b0;
        tick();
        chk("R7 one-clock run fault", {32'h0, de_fault}, 33'h1);

        // R8: one-clock run right after reset is not judged
        do_reset();
        drive(30'h9, 30'hA, 1'b0, 1'b0);
        tick();
        a_de = 1'b1; b_de = 1'b1;
        tick(); tick();
        a_de = 1'b0; b_de = 1'b0;
        tick(); tick();
        chk("R8 run at reset exempt", {32'h0, de_fault}, 33'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule